// File: doc/BRIEF.md
# Registered Narrow-Wide Bus Exchanger

This block moves data in either direction between one narrow port and a wide port built from two equal halves, called the first half and the second half. In the narrow-to-wide direction it packs two narrow words into one wide word. The first word is captured on a clock edge while the select input is low. On the next edge with select high, that word moves into the first-half output register, and the word then present on the narrow port loads into the second-half register. Both words then appear together on the wide side.

In the wide-to-narrow direction, both halves are captured on every clock edge. The select input then picks which stored half appears on the narrow port.

A direction input passes through a register before it takes effect. Together with an active-low enable, the registered direction decides which side drives. Each port gives a drive-enable signal beside its data in place of high-impedance values.

Top module: `bus_exchanger`

## Requirements
- R1: A synchronous active-high reset clears every data register to zero and sets the registered direction to wide-to-narrow (encoding 0). So after reset, with `oe_n` low, `nar_en` is 1 and `wide_en` is 0.
- R2: A rising edge with `sel` low captures `nar_in` into the first pipeline stage and leaves `wide1_out` and `wide2_out` unchanged.
- R3: A rising edge with `sel` high does two things at once: it copies the first pipeline stage to `wide1_out`, and it loads the current `nar_in` into `wide2_out`.
- R4: A narrow word captured at a select-low edge reaches `wide1_out` only at the following select-high edge, which is the second edge. Two select-high edges in a row put the same held word on `wide1_out` again.
- R5: `wide1_in` and `wide2_in` are registered on every rising edge. `nar_out` shows the stored first half when `sel` is 1 and the stored second half when `sel` is 0. A change of `sel` takes effect without a clock edge, and a change of the wide inputs between edges has no effect.
- R6: `dir_in` (1 = narrow-to-wide, 0 = wide-to-narrow) changes the drive enables only after the next rising edge.
- R7: While `oe_n` is 1, `nar_en` and `wide_en` are both 0, whatever the direction.
- R8: While `oe_n` is 0, `wide_en` equals the registered direction and `nar_en` is its inverse. The two enables are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers capture on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| oe_n | input | 1 | Active-low output enable for both ports |
| dir_in | input | 1 | Direction request, 1 = narrow-to-wide, registered |
| sel | input | 1 | Packing phase (narrow-to-wide) and half select (wide-to-narrow) |
| nar_in | input | WORD_W | Narrow port receive data |
| wide1_in | input | WORD_W | Wide first-half receive data |
| wide2_in | input | WORD_W | Wide second-half receive data |
| nar_out | output | WORD_W | Narrow port drive data |
| nar_en | output | 1 | Narrow port drives when 1 |
| wide1_out | output | WORD_W | Wide first-half drive data |
| wide2_out | output | WORD_W | Wide second-half drive data |
| wide_en | output | 1 | Both wide halves drive when 1 |

## Verification
The bench builds the block with its default word width of 18 bits. At this width, word patterns that are all ones, alternating, or different in just the top or the bottom bit make any swap of the two halves visible. They also expose a stale pipeline stage or a truncated bit. Since the width does not change the control logic, the pack ordering, the select-driven half choice and the one-edge delay on direction are all covered at this single size.

// File: rtl/bus_exchanger_pkg.sv
package bus_exchanger_pkg;
  localparam int unsigned DEF_WORD_W = 18;

  typedef enum logic {
    DIR_WIDE2NAR = 1'b0,
    DIR_NAR2WIDE = 1'b1
  } dir_e;

  // Returns {wide_en, nar_en} for a given enable and registered direction.
  function automatic logic [1:0] port_drive(input logic oe_n, input dir_e dir);
    logic [1:0] en;
    en = 2'b00;
    if (!oe_n) begin
      if (dir == DIR_NAR2WIDE) en = 2'b10;
      else                     en = 2'b01;
    end
    return en;
  endfunction
endpackage

// File: rtl/bus_exchanger_pack.sv
module bus_exchanger_pack #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel,
  input  logic [W-1:0] nar_in,
  output logic [W-1:0] wide1_q,
  output logic [W-1:0] wide2_q,
  output logic         load_first,
  output logic         advance
);
  logic [W-1:0] first_q;

  assign load_first = !sel;
  assign advance    = sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= '0;
      wide1_q <= '0;
      wide2_q <= '0;
    end else begin
      if (load_first) first_q <= nar_in;
      if (advance) begin
        wide1_q <= first_q;
        wide2_q <= nar_in;
      end
    end
  end
endmodule

// File: rtl/bus_exchanger_pick.sv
module bus_exchanger_pick #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel,
  input  logic [W-1:0] wide1_in,
  input  logic [W-1:0] wide2_in,
  output logic [W-1:0] nar_q
);
  logic [W-1:0] half_q [2];

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk) begin
      if (rst) half_q[h] <= '0;
      else     half_q[h] <= (h == 0) ? wide1_in : wide2_in;
    end
  end

  assign nar_q = sel ? half_q[0] : half_q[1];
endmodule

// File: rtl/bus_exchanger_dir.sv
module bus_exchanger_dir
  import bus_exchanger_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic oe_n,
  input  logic dir_in,
  output dir_e dir_q,
  output logic nar_en,
  output logic wide_en
);
  always_ff @(posedge clk) begin
    if (rst) dir_q <= DIR_WIDE2NAR;
    else     dir_q <= dir_e'(dir_in);
  end

  always_comb begin
    {wide_en, nar_en} = port_drive(oe_n, dir_q);
  end
endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger
  import bus_exchanger_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              oe_n,
  input  logic              dir_in,
  input  logic              sel,
  input  logic [WORD_W-1:0] nar_in,
  input  logic [WORD_W-1:0] wide1_in,
  input  logic [WORD_W-1:0] wide2_in,
  output logic [WORD_W-1:0] nar_out,
  output logic              nar_en,
  output logic [WORD_W-1:0] wide1_out,
  output logic [WORD_W-1:0] wide2_out,
  output logic              wide_en
);
  logic load_first;
  logic advance;
  dir_e dir_q;

  bus_exchanger_pack #(.W(WORD_W)) u_pack (
    .clk(clk), .rst(rst), .sel(sel), .nar_in(nar_in),
    .wide1_q(wide1_out), .wide2_q(wide2_out),
    .load_first(load_first), .advance(advance)
  );

  bus_exchanger_pick #(.W(WORD_W)) u_pick (
    .clk(clk), .rst(rst), .sel(sel),
    .wide1_in(wide1_in), .wide2_in(wide2_in), .nar_q(nar_out)
  );

  bus_exchanger_dir u_dir (
    .clk(clk), .rst(rst), .oe_n(oe_n), .dir_in(dir_in),
    .dir_q(dir_q), .nar_en(nar_en), .wide_en(wide_en)
  );
endmodule

// File: rtl/bus_exchanger_chk.sv
module bus_exchanger_chk #(
  parameter int unsigned W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic         oe_n,
  input logic         dir_in,
  input logic         sel,
  input logic [W-1:0] nar_in,
  input logic [W-1:0] wide1_in,
  input logic [W-1:0] wide2_in,
  input logic [W-1:0] nar_out,
  input logic         nar_en,
  input logic [W-1:0] wide1_out,
  input logic [W-1:0] wide2_out,
  input logic         wide_en,
  input logic         load_first,
  input logic         advance
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (!nar_en && !wide_en));

  assert_one_driver_R8: assert property (@(posedge clk) disable iff (rst)
    !(nar_en && wide_en));

  assert_dir_delay_R6: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (wide_en == (!oe_n && $past(dir_in))));

  assert_hold_on_low_R2: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(load_first)) |-> ($stable(wide1_out) && $stable(wide2_out)));

  assert_second_load_R3: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(advance)) |-> (wide2_out == $past(nar_in)));

  assert_half_pick_R5: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (nar_out == (sel ? $past(wide1_in) : $past(wide2_in))));
endmodule

bind bus_exchanger bus_exchanger_chk #(.W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .oe_n(oe_n), .dir_in(dir_in), .sel(sel),
  .nar_in(nar_in), .wide1_in(wide1_in), .wide2_in(wide2_in),
  .nar_out(nar_out), .nar_en(nar_en), .wide1_out(wide1_out),
  .wide2_out(wide2_out), .wide_en(wide_en),
  .load_first(load_first), .advance(advance)
);

// File: tb/bus_exchanger_tb.sv
module bus_exchanger_tb;
  localparam int unsigned W = 18;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst, oe_n, dir_in, sel;
  logic [W-1:0] nar_in, wide1_in, wide2_in;
  logic [W-1:0] nar_out, wide1_out, wide2_out;
  logic nar_en, wide_en;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_exchanger #(.WORD_W(W)) u_dut (
    .clk(clk), .rst(rst), .oe_n(oe_n), .dir_in(dir_in), .sel(sel),
    .nar_in(nar_in), .wide1_in(wide1_in), .wide2_in(wide2_in),
    .nar_out(nar_out), .nar_en(nar_en), .wide1_out(wide1_out),
    .wide2_out(wide2_out), .wide_en(wide_en)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst = 1; oe_n = 0; dir_in = 1; sel = 1;
    nar_in = '1; wide1_in = '1; wide2_in = '1;
    tick(); tick();
    chk("R1 wide1_out", wide1_out, '0);
    chk("R1 wide2_out", wide2_out, '0);
    chk("R1 nar_out", nar_out, '0);
    chk("R1 nar_en", W'(nar_en), W'(1));
    chk("R1 wide_en", W'(wide_en), W'(0));
    rst = 0; dir_in = 0;
    tick();
  endtask

  task automatic t_pack(input logic [W-1:0] w0, input logic [W-1:0] w1);
    logic [W-1:0] old1, old2;
    old1 = wide1_out; old2 = wide2_out;
    sel = 0; nar_in = w0;
    tick();
    chk("R2 wide1 held", wide1_out, old1);
    chk("R2 wide2 held", wide2_out, old2);
    sel = 1; nar_in = w1;
    tick();
    chk("R3/R4 wide1 first word", wide1_out, w0);
    chk("R3 wide2 second word", wide2_out, w1);
  endtask

  task automatic t_hold_and_repeat();
    sel = 0; nar_in = 18'h2AAAA;
    tick();
    nar_in = 18'h15555;
    tick();
    chk("R2 held after low edges wide1", wide1_out, 18'h3FFFF);
    chk("R2 held after low edges wide2", wide2_out, 18'h00001);
    sel = 1; nar_in = 18'h0F0F0;
    tick();
    chk("R4 last low word wins", wide1_out, 18'h15555);
    nar_in = 18'h30303;
    tick();
    chk("R4 repeated high keeps held word", wide1_out, 18'h15555);
    chk("R3 repeated high loads wide2", wide2_out, 18'h30303);
  endtask

  task automatic t_pick();
    wide1_in = 18'h12345; wide2_in = 18'h2BCDE;
    sel = 1;
    tick();
    chk("R5 sel high picks first half", nar_out, 18'h12345);
    sel = 0; #1;
    chk("R5 sel low picks second half", nar_out, 18'h2BCDE);
    wide2_in = 18'h00F00; #1;
    chk("R5 no change between edges", nar_out, 18'h2BCDE);
    tick();
    chk("R5 new second half after edge", nar_out, 18'h00F00);
  endtask

  task automatic t_dir();
    oe_n = 0; dir_in = 1; #1;
    chk("R6 nar_en before edge", W'(nar_en), W'(1));
    chk("R6 wide_en before edge", W'(wide_en), W'(0));
    tick();
    chk("R8 wide_en narrow-to-wide", W'(wide_en), W'(1));
    chk("R8 nar_en narrow-to-wide", W'(nar_en), W'(0));
    dir_in = 0; #1;
    chk("R6 wide_en holds before edge", W'(wide_en), W'(1));
    tick();
    chk("R8 nar_en wide-to-narrow", W'(nar_en), W'(1));
    chk("R8 wide_en wide-to-narrow", W'(wide_en), W'(0));
  endtask

  task automatic t_oe();
    oe_n = 1; #1;
    chk("R7 nar_en off", W'(nar_en), W'(0));
    chk("R7 wide_en off", W'(wide_en), W'(0));
    dir_in = 1;
    tick();
    chk("R7 nar_en off after dir", W'(nar_en), W'(0));
    chk("R7 wide_en off after dir", W'(wide_en), W'(0));
    oe_n = 0; #1;
    chk("R8 enable restores wide", W'(wide_en), W'(1));
  endtask

  initial begin
    t_reset();
    t_pack(18'h3FFFF, 18'h00001);
    t_hold_and_repeat();
    t_pack(18'h20000, 18'h00001);
    t_pack(18'h00001, 18'h20000);
    t_pick();
    t_dir();
    t_oe();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule